// File: doc/BRIEF.md
# Program Sequencer with Skip Qualifier

This block produces the instruction ROM address for a small signal-processing controller. It also decides whether each fetched instruction is allowed to take effect. An 8-bit program counter forms the low address bits. An external bank level supplies the top address bit. Without a jump, the counter advances by one every instruction clock and wraps around. A jump, whether unconditional or taken only while the interrupt flag is set, loads the counter from the low ALU result bits. That load lands one instruction late, so the instruction after the jump always runs as a delay slot.

A 3-bit condition code picks one status input: the ALU sign, the carry out, the overflow flag, one of their combinations, or a constant. When the picked input is low, the following instruction is marked as skipped. While `exec_en` is low, the surrounding datapath must drop register writes, destination decode and I/O strobes. Inside this block, a skipped instruction can neither jump nor clear the interrupt flag. The selector is switched off by the inhibit bit of the instruction word, and it is also switched off for the one cycle right after a skip, so skips never chain.

Top module: `seq_core`

## Requirements
- R1: While `rst` is high at a clock edge, the counter is cleared, the skip state is cleared and the interrupt flag is cleared. After that edge `rom_addr[7:0]` is 0, `exec_en` is 1 and `irq_flag` is 0. `ir_load` is 0 while `rst` is high and 1 otherwise.
- R2: With no jump pending, `rom_addr[7:0]` increases by one at every clock edge and wraps from 255 to 0.
- R3: `rom_addr[8]` always equals `bank_sel`, with no clock delay, so toggling the bank moves the address by 256 at once.
- R4: If `jump_req` is high in an executing cycle, the next address is the sequential one (the delay slot). The address after that is `alu_target`, as it was sampled in the jump cycle.
- R5: `jump_irq_req` loads the counter in the same delayed way, but only when `irq_flag` is 1 in that cycle. Otherwise it has no effect.
- R6: `skip_sel` picks a condition input: 0 = constant 1, 1 = `alu_sign`, 2 = `alu_carry`, 3 = NOT `alu_sign`, 4 = `ovf_flag`, 5 = `ovf_flag` OR `alu_sign`, 6 = `ovf_flag` OR NOT `alu_sign`, 7 = constant 0. If the picked input is 0 in an executing cycle, `exec_en` is 0 in the next cycle.
- R7: In a cycle with `exec_en` = 0, `jump_req`, `jump_irq_req` and `irq_clear` have no effect.
- R8: When `skip_inhibit` (instruction bit 31) is high, no skip is produced for the next cycle.
- R9: A skipped cycle cannot produce a skip. `exec_en` is never 0 in two consecutive cycles.
- R10: `irq_set` makes `irq_flag` 1 on the next cycle. `irq_clear` in an executing cycle makes it 0, unless `irq_set` is high in the same cycle, in which case set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Bank level, top ROM address bit |
| jump_req | input | 1 | Unconditional delayed jump |
| jump_irq_req | input | 1 | Delayed jump taken only with interrupt flag set |
| alu_target | input | 8 | Low ALU result bits, jump target |
| alu_sign | input | 1 | ALU result sign bit |
| alu_carry | input | 1 | ALU carry out |
| ovf_flag | input | 1 | Overflow status input |
| skip_sel | input | 3 | Skip condition code |
| skip_inhibit | input | 1 | Instruction bit 31, disables the condition selector |
| irq_set | input | 1 | External interrupt request |
| irq_clear | input | 1 | I/O function that clears the interrupt flag |
| rom_addr | output | 9 | Instruction ROM address |
| ir_load | output | 1 | Instruction register load enable |
| exec_en | output | 1 | High when the current instruction takes effect |
| irq_flag | output | 1 | Interrupt flag |

## Verification
The bench builds the block with its defaults: an 8-bit counter and one bank bit. This small size lets a single idle run cover the whole 256-entry address space, including the wrap from 255 to 0. The bench sweeps every combination of condition code, sign, carry, overflow and inhibit, each one starting from a clean skip state. It adds the ordered cases that the sweep cannot reach: jumps placed back to back and inside delay slots, jumps and interrupt clears that land in skipped slots, two skip instructions in a row, and set and clear arriving together.

// File: rtl/seq_core_pkg.sv
package seq_core_pkg;

   typedef enum logic [2:0] {
      SK_NEVER   = 3'd0,
      SK_NEG     = 3'd1,
      SK_CARRY   = 3'd2,
      SK_POS     = 3'd3,
      SK_OVF     = 3'd4,
      SK_OVF_NEG = 3'd5,
      SK_OVF_POS = 3'd6,
      SK_ALWAYS  = 3'd7
   } skip_code_e;

   typedef struct packed {
      logic sign;
      logic carry;
      logic ovf;
   } status_t;

   localparam int unsigned SKIP_SEL_W = 3;

endpackage

// File: rtl/seq_pc_unit.sv
module seq_pc_unit #(
   parameter int unsigned PC_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load_req,
   input  logic [PC_W-1:0] load_tgt,
   output logic [PC_W-1:0] pc
);

   localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

   logic            pend_q;
   logic [PC_W-1:0] tgt_q;
   logic [PC_W-1:0] pc_q;

   // Target is held for one instruction so the delay slot executes first.
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         tgt_q  <= '0;
         pc_q   <= '0;
      end else begin
         pend_q <= load_req;
         if (load_req) tgt_q <= load_tgt;
         if (pend_q) pc_q <= tgt_q;
         else        pc_q <= pc_q + PC_ONE;
      end
   end

   assign pc = pc_q;

endmodule

// File: rtl/seq_skip_unit.sv
module seq_skip_unit
   import seq_core_pkg::*;
#(
   parameter bit BLOCK_CHAIN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [SKIP_SEL_W-1:0] sel,
   input  logic                  inhibit,
   input  status_t               status,
   output logic                  skip_q
);

   localparam int unsigned N_COND = 1 << SKIP_SEL_W;

   logic [N_COND-1:0] cond_vec;
   logic              sel_en;
   logic              cond_hit;
   logic              skip_r;

   always_comb begin
      cond_vec             = '0;
      cond_vec[SK_NEVER]   = 1'b1;
      cond_vec[SK_NEG]     = status.sign;
      cond_vec[SK_CARRY]   = status.carry;
      cond_vec[SK_POS]     = ~status.sign;
      cond_vec[SK_OVF]     = status.ovf;
      cond_vec[SK_OVF_NEG] = status.ovf | status.sign;
      cond_vec[SK_OVF_POS] = status.ovf | ~status.sign;
      cond_vec[SK_ALWAYS]  = 1'b0;
   end

   assign cond_hit = cond_vec[sel];

   generate
      if (BLOCK_CHAIN) begin : g_block
         assign sel_en = ~inhibit & ~skip_r;
      end else begin : g_chain
         assign sel_en = ~inhibit;
      end
   endgenerate

   // Low selected input means the following instruction is dropped.
   always_ff @(posedge clk) begin
      if (rst) skip_r <= 1'b0;
      else     skip_r <= sel_en & ~cond_hit;
   end

   assign skip_q = skip_r;

endmodule

// File: rtl/seq_irq_flag.sv
module seq_irq_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_req,
   input  logic clr_req,
   output logic flag
);

   logic flag_q;

   always_ff @(posedge clk) begin
      if (rst)          flag_q <= 1'b0;
      else if (set_req) flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
   end

   assign flag = flag_q;

endmodule

// File: rtl/seq_core.sv
module seq_core
   import seq_core_pkg::*;
#(
   parameter int unsigned PC_W        = 8,
   parameter int unsigned BANK_W      = 1,
   parameter bit          BLOCK_CHAIN = 1'b1,
   localparam int unsigned BANK_SW    = (BANK_W > 0) ? BANK_W : 1,
   localparam int unsigned ROM_AW     = PC_W + BANK_W
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [BANK_SW-1:0]    bank_sel,
   input  logic                  jump_req,
   input  logic                  jump_irq_req,
   input  logic [PC_W-1:0]       alu_target,
   input  logic                  alu_sign,
   input  logic                  alu_carry,
   input  logic                  ovf_flag,
   input  logic [SKIP_SEL_W-1:0] skip_sel,
   input  logic                  skip_inhibit,
   input  logic                  irq_set,
   input  logic                  irq_clear,
   output logic [ROM_AW-1:0]     rom_addr,
   output logic                  ir_load,
   output logic                  exec_en,
   output logic                  irq_flag
);

   generate
      if (PC_W < 2 || PC_W > 16) begin : g_bad_pc
         $error("seq_core: PC_W must lie in 2..16");
      end
      if (BANK_W > 2) begin : g_bad_bank
         $error("seq_core: BANK_W must be 0, 1 or 2");
      end
   endgenerate

   logic            skip_q;
   logic            irq_q;
   logic            take_jump;
   logic [PC_W-1:0] pc;
   status_t         stat;

   assign stat      = '{sign: alu_sign, carry: alu_carry, ovf: ovf_flag};
   assign exec_en   = ~skip_q;
   assign take_jump = exec_en & (jump_req | (jump_irq_req & irq_q));
   assign ir_load   = ~rst;
   assign irq_flag  = irq_q;

   seq_pc_unit #(.PC_W(PC_W)) u_pc (
      .clk      (clk),
      .rst      (rst),
      .load_req (take_jump),
      .load_tgt (alu_target),
      .pc       (pc)
   );

   seq_skip_unit #(.BLOCK_CHAIN(BLOCK_CHAIN)) u_skip (
      .clk     (clk),
      .rst     (rst),
      .sel     (skip_sel),
      .inhibit (skip_inhibit),
      .status  (stat),
      .skip_q  (skip_q)
   );

   seq_irq_flag u_irq (
      .clk     (clk),
      .rst     (rst),
      .set_req (irq_set),
      .clr_req (irq_clear & exec_en),
      .flag    (irq_q)
   );

   generate
      if (BANK_W == 0) begin : g_nobank
         assign rom_addr = pc;
      end else begin : g_bank
         assign rom_addr = {bank_sel[BANK_W-1:0], pc};
      end
   endgenerate

endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk #(
   parameter int unsigned PC_W   = 8,
   parameter int unsigned ROM_AW = 9
) (
   input logic              clk,
   input logic              rst,
   input logic              jump_req,
   input logic [PC_W-1:0]   alu_target,
   input logic [2:0]        skip_sel,
   input logic              skip_inhibit,
   input logic              irq_set,
   input logic [ROM_AW-1:0] rom_addr,
   input logic              exec_en,
   input logic              irq_flag
);

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (rom_addr[PC_W-1:0] == '0) && exec_en && !irq_flag);

   a_r4_delay_slot: assert property (@(posedge clk) disable iff (rst)
      (exec_en && jump_req) |=> ##1 (rom_addr[PC_W-1:0] == $past(alu_target, 2)));

   a_r6_never_code: assert property (@(posedge clk) disable iff (rst)
      (skip_sel == 3'd0) |=> exec_en);

   a_r8_inhibit: assert property (@(posedge clk) disable iff (rst)
      skip_inhibit |=> exec_en);

   a_r9_no_chain: assert property (@(posedge clk) disable iff (rst)
      !exec_en |=> exec_en);

   a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
      irq_set |=> irq_flag);

endmodule

bind seq_core seq_core_chk #(.PC_W(PC_W), .ROM_AW(ROM_AW)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .jump_req     (jump_req),
   .alu_target   (alu_target),
   .skip_sel     (skip_sel),
   .skip_inhibit (skip_inhibit),
   .irq_set      (irq_set),
   .rom_addr     (rom_addr),
   .exec_en      (exec_en),
   .irq_flag     (irq_flag)
);

// File: tb/tb_seq_core.sv
module tb_seq_core;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bank_sel = 1'b0;
   logic       jump_req = 1'b0;
   logic       jump_irq_req = 1'b0;
   logic [7:0] alu_target = 8'h00;
   logic       alu_sign = 1'b0;
   logic       alu_carry = 1'b0;
   logic       ovf_flag = 1'b0;
   logic [2:0] skip_sel = 3'd0;
   logic       skip_inhibit = 1'b0;
   logic       irq_set = 1'b0;
   logic       irq_clear = 1'b0;
   logic [8:0] rom_addr;
   logic       ir_load;
   logic       exec_en;
   logic       irq_flag;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] m_pc = 8'h00;
   logic       m_pend = 1'b0;
   logic [7:0] m_tgt = 8'h00;
   logic       m_skip = 1'b0;
   logic       m_irq = 1'b0;

   always #5 clk = ~clk;

   seq_core dut (
      .clk(clk), .rst(rst), .bank_sel(bank_sel), .jump_req(jump_req),
      .jump_irq_req(jump_irq_req), .alu_target(alu_target),
      .alu_sign(alu_sign), .alu_carry(alu_carry), .ovf_flag(ovf_flag),
      .skip_sel(skip_sel), .skip_inhibit(skip_inhibit), .irq_set(irq_set),
      .irq_clear(irq_clear), .rom_addr(rom_addr), .ir_load(ir_load),
      .exec_en(exec_en), .irq_flag(irq_flag)
   );

   function automatic logic cond_of(input logic [2:0] s, input logic sg,
                                    input logic cy, input logic ov);
      case (s)
         3'd0: return 1'b1;
         3'd1: return sg;
         3'd2: return cy;
         3'd3: return ~sg;
         3'd4: return ov;
         3'd5: return ov | sg;
         3'd6: return ov | ~sg;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      jump_req = 0; jump_irq_req = 0; skip_sel = 0; skip_inhibit = 0;
      irq_set = 0; irq_clear = 0; alu_sign = 0; alu_carry = 0; ovf_flag = 0;
   endtask

   // Advance one instruction with current inputs and compare all outputs.
   task automatic step(input string tag);
      logic ex, nskip, take;
      ex    = !m_skip;
      nskip = !skip_inhibit && !m_skip &&
              !cond_of(skip_sel, alu_sign, alu_carry, ovf_flag);
      take  = ex && (jump_req || (jump_irq_req && m_irq));
      @(posedge clk);
      if (rst) begin
         m_pc = 0; m_pend = 0; m_tgt = 0; m_skip = 0; m_irq = 0;
      end else begin
         m_pc = m_pend ? m_tgt : m_pc + 8'd1;
         m_pend = take;
         if (take) m_tgt = alu_target;
         m_skip = nskip;
         if (irq_set) m_irq = 1;
         else if (irq_clear && ex) m_irq = 0;
      end
      @(negedge clk);
      chk(tag, "rom_addr", {23'd0, rom_addr}, {23'd0, bank_sel, m_pc});
      chk(tag, "exec_en", {31'd0, exec_en}, {31'd0, !m_skip});
      chk(tag, "irq_flag", {31'd0, irq_flag}, {31'd0, m_irq});
      chk(tag, "ir_load", {31'd0, ir_load}, {31'd0, !rst});
   endtask

   initial begin
      @(negedge clk);
      idle_inputs();
      // R1: reset state
      rst = 1; step("R1"); step("R1");
      rst = 0; step("R1");
      // R2: full sweep through wrap
      for (int i = 0; i < 300; i++) step("R2");
      // R3: bank toggles move the address immediately
      for (int i = 0; i < 4; i++) begin
         bank_sel = ~bank_sel; #1;
         chk("R3", "rom_addr", {23'd0, rom_addr}, {23'd0, bank_sel, m_pc});
         step("R3");
      end
      bank_sel = 0;
      // R4: delayed jumps, including back-to-back
      for (int t = 0; t < 256; t += 37) begin
         jump_req = 1; alu_target = t[7:0]; step("R4");
         jump_req = 0; step("R4"); step("R4"); step("R4");
      end
      jump_req = 1; alu_target = 8'hF0; step("R4");
      alu_target = 8'h10; step("R4");
      jump_req = 0; step("R4"); step("R4"); step("R4");
      // R5: interrupt-qualified jump
      jump_irq_req = 1; alu_target = 8'h55; step("R5");
      jump_irq_req = 0; step("R5"); step("R5");
      irq_set = 1; step("R10"); irq_set = 0;
      jump_irq_req = 1; alu_target = 8'h66; step("R5");
      jump_irq_req = 0; step("R5"); step("R5");
      // R10: set wins over clear; clear alone works
      irq_set = 1; irq_clear = 1; step("R10");
      irq_set = 0; step("R10"); step("R10");
      // R6/R8: sweep every condition code, flag and inhibit combination
      for (int v = 0; v < 128; v++) begin
         idle_inputs(); step("R6");
         skip_sel = v[2:0]; alu_sign = v[3]; alu_carry = v[4];
         ovf_flag = v[5]; skip_inhibit = v[6];
         step(v[6] ? "R8" : "R6");
         idle_inputs(); step("R6");
      end
      // R9: two skip-always in a row
      skip_sel = 7; step("R9"); step("R9"); step("R9");
      idle_inputs(); step("R9"); step("R9");
      // R7: jump and irq clear inside a skipped slot
      skip_sel = 7; step("R7");
      skip_sel = 0; jump_req = 1; alu_target = 8'hAA; irq_clear = 1; step("R7");
      jump_req = 0; irq_clear = 0; step("R7"); step("R7"); step("R7");
      skip_sel = 7; step("R7");
      skip_sel = 0; jump_irq_req = 1; alu_target = 8'h33; step("R7");
      jump_irq_req = 0; step("R7"); step("R7");
      irq_clear = 1; step("R10"); irq_clear = 0; step("R10");
      // R1: reset mid-run
      rst = 1; step("R1"); rst = 0; step("R1"); step("R2");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule